// File: doc/BRIEF.md
# Lockable Watchdog Timer with Pretimeout

This block is a watchdog peripheral split across two clocks. Software reaches a set of 16-bit registers on the bus clock. The down-counter runs on a slow counter clock, nominally 32768 ticks per second. Software writes a 32-bit timeout and a 32-bit pretimeout threshold, each as two 16-bit halves. It starts the counter from the control register. The block raises an interrupt when the count passes the threshold. It raises a reset request when the count runs out.

Every register except the key register is write-protected. Writes take effect only while the key register holds 0xE551. Writing the low half of the timeout commits both 32-bit values to the counter domain through a toggle handshake. A busy flag stays set until the counter domain acknowledges the transfer. The live count returns to the bus domain in Gray code. Reading the upper half latches the lower half, so the two reads form one coherent value. The pretimeout halves must be written before the timeout low half.

Top module: `lockable_wdt`

## Requirements
- R1: A write to any register other than the key register (byte offset 0x20) changes nothing unless the key register holds 0xE551. A write to the key register always takes effect, and any value other than 0xE551 locks the block again.
- R2: Reading the key register returns 1 in bit 0 when the block is unlocked and 0 when it is locked.
- R3: These byte offsets read back their stored values: timeout low 0x00, timeout high 0x04, control 0x08 (4 bits), mask 0x14 (bit 0), pretimeout low 0x2C, pretimeout high 0x30. After reset all of them read 0, the status register (0x10) reads 0, and both outputs are low.
- R4: An accepted write to timeout low sets status bit 4 (busy) from the next bus cycle. Busy clears within a bounded number of cycles. Once the transfer is done, a stopped counter holds the 32-bit value {timeout high, timeout low}.
- R5: While control bit 1 is set, the count drops by one per counter-clock cycle. While bit 1 is clear, the count holds its value.
- R6: When the count steps down to the pretimeout value, status bit 0 (pretimeout pending) is set.
- R7: When the count steps from 1 to 0, status bit 3 (expiry pending) is set, and the count then stays at 0.
- R8: irq_o is high exactly when status bit 0 is set, control bit 0 is set and mask bit 0 is clear.
- R9: rst_req_o is high exactly when status bit 3 is set and control bit 3 is set. It stays high until bit 3 is cleared or control bit 3 is cleared.
- R10: Writing the clear register (0x0C) with bit 0 set clears status bit 0. Writing it with bit 3 set clears status bit 3. Pending bits otherwise persist.
- R11: The count is read as the upper half at 0x1C, then the lower half at 0x18. The lower half returned is the one latched when the upper half was read, so the pair is coherent even while the counter runs.
- R12: A write to timeout low while busy is set is dropped entirely. Neither the stored register nor the counter sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| cnt_clk_i | input | 1 | Slow counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| req_i | input | 1 | Bus access strobe, one bus cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on addr_i |
| irq_o | output | 1 | Pretimeout interrupt |
| rst_req_o | output | 1 | System reset request |

## Verification
Suppose the handshake toggle and its acknowledge drift apart. Busy then either never clears or clears with a stale count, and both show on the next status and count reads after a commit. A counter that misses or repeats a step shows as a count outside its expected window a few counter cycles after enabling. It also shows as a pending bit that rises at the wrong count or never rises. A broken Gray path or snapshot shows as a count pair far from its neighbours when the count crosses a 16-bit boundary, within one pair of reads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_TMO_LO  = 6'h00;
  localparam logic [ADDR_W-1:0] A_TMO_HI  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h08;
  localparam logic [ADDR_W-1:0] A_CLR     = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT    = 6'h10;
  localparam logic [ADDR_W-1:0] A_MASK    = 6'h14;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 6'h18;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_KEY     = 6'h20;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 6'h2C;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 6'h30;

  localparam logic [15:0] UNLOCK_KEY = 16'hE551;

  localparam int CTL_W      = 4;
  localparam int CTL_INT_EN = 0;
  localparam int CTL_CNT_EN = 1;
  localparam int CTL_RST_EN = 3;

  localparam int ST_INT  = 0;
  localparam int ST_RST  = 3;
  localparam int ST_BUSY = 4;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic [CNT_W-1:0] pre_i,
  output logic             ack_o,
  output logic             pre_tgl_o,
  output logic             exp_tgl_o,
  output logic [CNT_W-1:0] gray_o
);
  logic             req_q;
  logic             load_stb;
  logic [CNT_W-1:0] count_q, thr_q, dec;
  logic             pre_tgl_q, exp_tgl_q;
  logic [CNT_W-1:0] gray_q;

  assign load_stb = req_i ^ req_q;
  assign dec      = count_q - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      count_q   <= '0;
      thr_q     <= '0;
      pre_tgl_q <= 1'b0;
      exp_tgl_q <= 1'b0;
      gray_q    <= '0;
    end else begin
      req_q  <= req_i;
      gray_q <= count_q ^ (count_q >> 1);
      if (load_stb) begin
        count_q <= tmo_i;
        thr_q   <= pre_i;
      end else if (en_i && count_q != '0) begin
        count_q <= dec;
        if (dec == thr_q) pre_tgl_q <= ~pre_tgl_q;
        if (dec == '0)    exp_tgl_q <= ~exp_tgl_q;
      end
    end
  end

  assign ack_o     = req_q;
  assign pre_tgl_o = pre_tgl_q;
  assign exp_tgl_o = exp_tgl_q;
  assign gray_o    = gray_q;

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb |=> count_q == $past(tmo_i));
  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_stb && en_i && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));
  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_stb && !en_i) |=> $stable(count_q));
  p_zero_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_stb && count_q == '0) |=> count_q == '0);
  p_expire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_stb && en_i && count_q == CNT_W'(1)) |=> exp_tgl_q != $past(exp_tgl_q));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              cnt_en_o,
  output logic              req_tgl_o,
  output logic [CNT_W-1:0]  tmo_o,
  output logic [CNT_W-1:0]  pre_o,
  input  logic              ack_i,
  input  logic              pre_ev_i,
  input  logic              exp_ev_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [15:0]       key_q;
  logic [HALF_W-1:0] tmo_lo_q, tmo_hi_q, pre_lo_q, pre_hi_q, snap_lo_q;
  logic [CTL_W-1:0]  ctrl_q;
  logic              mask_q;
  logic [CNT_W-1:0]  tmo_hold_q, pre_hold_q;
  logic              req_tgl_q;
  logic              pre_seen_q, exp_seen_q;
  logic              int_pend_q, rst_pend_q;

  logic unlocked, wr, wr_ok, busy, commit, pre_hit, exp_hit, clr_int, clr_rst;

  assign unlocked = key_q == UNLOCK_KEY;
  assign wr       = req_i && we_i;
  assign wr_ok    = wr && unlocked;
  assign busy     = req_tgl_q ^ ack_i;
  assign commit   = wr_ok && addr_i == A_TMO_LO && !busy;
  assign pre_hit  = pre_ev_i ^ pre_seen_q;
  assign exp_hit  = exp_ev_i ^ exp_seen_q;
  assign clr_int  = wr_ok && addr_i == A_CLR && wdata_i[ST_INT];
  assign clr_rst  = wr_ok && addr_i == A_CLR && wdata_i[ST_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q      <= '0;
      tmo_lo_q   <= '0;
      tmo_hi_q   <= '0;
      pre_lo_q   <= '0;
      pre_hi_q   <= '0;
      snap_lo_q  <= '0;
      ctrl_q     <= '0;
      mask_q     <= 1'b0;
      tmo_hold_q <= '0;
      pre_hold_q <= '0;
      req_tgl_q  <= 1'b0;
      pre_seen_q <= 1'b0;
      exp_seen_q <= 1'b0;
      int_pend_q <= 1'b0;
      rst_pend_q <= 1'b0;
    end else begin
      if (wr && addr_i == A_KEY) key_q <= 16'(wdata_i);
      if (wr_ok) begin
        case (addr_i)
          A_TMO_HI: tmo_hi_q <= wdata_i;
          A_CTRL:   ctrl_q   <= wdata_i[CTL_W-1:0];
          A_MASK:   mask_q   <= wdata_i[0];
          A_PRE_LO: pre_lo_q <= wdata_i;
          A_PRE_HI: pre_hi_q <= wdata_i;
          default: ;
        endcase
      end
      if (commit) begin
        tmo_lo_q   <= wdata_i;
        tmo_hold_q <= {tmo_hi_q, wdata_i};
        pre_hold_q <= {pre_hi_q, pre_lo_q};
        req_tgl_q  <= ~req_tgl_q;
      end
      if (req_i && !we_i && addr_i == A_CNT_HI) snap_lo_q <= cnt_i[HALF_W-1:0];
      pre_seen_q <= pre_ev_i;
      exp_seen_q <= exp_ev_i;
      int_pend_q <= pre_hit || (int_pend_q && !clr_int);
      rst_pend_q <= exp_hit || (rst_pend_q && !clr_rst);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_TMO_LO: rdata_o = tmo_lo_q;
      A_TMO_HI: rdata_o = tmo_hi_q;
      A_CTRL:   rdata_o = HALF_W'(ctrl_q);
      A_STAT: begin
        rdata_o[ST_INT]  = int_pend_q;
        rdata_o[ST_RST]  = rst_pend_q;
        rdata_o[ST_BUSY] = busy;
      end
      A_MASK:   rdata_o = HALF_W'(mask_q);
      A_CNT_LO: rdata_o = snap_lo_q;
      A_CNT_HI: rdata_o = cnt_i[CNT_W-1:HALF_W];
      A_KEY:    rdata_o = HALF_W'(unlocked);
      A_PRE_LO: rdata_o = pre_lo_q;
      A_PRE_HI: rdata_o = pre_hi_q;
      default:  rdata_o = '0;
    endcase
  end

  assign cnt_en_o  = ctrl_q[CTL_CNT_EN];
  assign req_tgl_o = req_tgl_q;
  assign tmo_o     = tmo_hold_q;
  assign pre_o     = pre_hold_q;
  assign irq_o     = int_pend_q && ctrl_q[CTL_INT_EN] && !mask_q;
  assign rst_req_o = rst_pend_q && ctrl_q[CTL_RST_EN];

  p_locked_ctrl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !unlocked && addr_i == A_CTRL) |=> $stable(ctrl_q));
  p_busy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy);
  p_hold_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(tmo_hold_q) && $stable(tmo_lo_q));
  p_pend_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_pend_q && !clr_int) |=> int_pend_q);
  p_rst_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pend_q && !clr_rst) |=> rst_pend_q);
endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
  import wdt_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              cnt_clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic             cnt_en, req_tgl, ack, pre_tgl, exp_tgl;
  logic             cnt_en_s, req_s, ack_s, pre_s, exp_s;
  logic [CNT_W-1:0] tmo_hold, pre_hold, gray_c, gray_b, cnt_b;

  wdt_regs #(.HALF_W(HALF_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_en_o(cnt_en), .req_tgl_o(req_tgl), .tmo_o(tmo_hold), .pre_o(pre_hold),
    .ack_i(ack_s), .pre_ev_i(pre_s), .exp_ev_i(exp_s), .cnt_i(cnt_b),
    .irq_o, .rst_req_o
  );

  wdt_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync_to_cnt (
    .clk_i(cnt_clk_i), .rst_ni, .d_i({req_tgl, cnt_en}), .q_o({req_s, cnt_en_s})
  );

  wdt_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i(cnt_clk_i), .rst_ni, .en_i(cnt_en_s), .req_i(req_s),
    .tmo_i(tmo_hold), .pre_i(pre_hold), .ack_o(ack),
    .pre_tgl_o(pre_tgl), .exp_tgl_o(exp_tgl), .gray_o(gray_c)
  );

  wdt_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync_evt (
    .clk_i, .rst_ni, .d_i({ack, pre_tgl, exp_tgl}), .q_o({ack_s, pre_s, exp_s})
  );

  wdt_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) i_sync_cnt (
    .clk_i, .rst_ni, .d_i(gray_c), .q_o(gray_b)
  );

  always_comb begin
    for (int i = 0; i < CNT_W; i++) cnt_b[i] = ^(gray_b >> i);
  end
endmodule

// File: tb/test_lockable_wdt.sv
module test_lockable_wdt;
  import wdt_pkg::*;

  logic        clk_i = 1'b0, cnt_clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0, fails = 0, cyc = 0;

  lockable_wdt i_lockable_wdt (
    .clk_i, .cnt_clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .rst_req_o
  );

  always #5 clk_i = ~clk_i;
  always #37 cnt_clk_i = ~cnt_clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic check_rng(string tag, logic [31:0] got, logic [31:0] lo, logic [31:0] hi);
    checks++;
    if (got < lo || got > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic read_cnt(output logic [31:0] v);
    logic [15:0] h, l;
    bus_rd(A_CNT_HI, h);
    bus_rd(A_CNT_LO, l);
    v = {h, l};
  endtask

  task automatic wait_cnt(int n);
    repeat (n) @(posedge cnt_clk_i);
    @(negedge clk_i);
  endtask

  task automatic wait_idle(string tag);
    logic [15:0] s;
    int n = 0;
    do begin
      bus_rd(A_STAT, s);
      n++;
    end while (s[ST_BUSY] && n < 200);
    check(tag, 32'(s[ST_BUSY]), 0);
    wait_cnt(4);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    bus_rd(A_STAT, d); check("R3 status after reset", d, 0);
    bus_rd(A_CTRL, d); check("R3 ctrl after reset", d, 0);
    bus_rd(A_KEY, d);  check("R2 locked after reset", d, 0);
    check("R3 irq after reset", 32'(irq_o), 0);
    check("R3 rst_req after reset", 32'(rst_req_o), 0);
  endtask

  task automatic t_lock;
    logic [15:0] d;
    bus_wr(A_CTRL, 16'hF);
    bus_rd(A_CTRL, d); check("R1 locked write ignored", d, 0);
    bus_wr(A_KEY, UNLOCK_KEY);
    bus_rd(A_KEY, d); check("R2 unlocked reads 1", d, 1);
    bus_wr(A_CTRL, 16'h4);
    bus_rd(A_CTRL, d); check("R1 unlocked write", d, 4);
    bus_wr(A_KEY, 16'h0);
    bus_rd(A_KEY, d); check("R2 relocked reads 0", d, 0);
    bus_wr(A_CTRL, 16'h0);
    bus_rd(A_CTRL, d); check("R1 relocked write ignored", d, 4);
    bus_wr(A_KEY, UNLOCK_KEY);
    bus_wr(A_CTRL, 16'h0);
  endtask

  task automatic t_load;
    logic [15:0] d;
    logic [31:0] v;
    bus_wr(A_PRE_HI, 16'h0);
    bus_wr(A_PRE_LO, 16'd20);
    bus_wr(A_TMO_HI, 16'h0);
    bus_wr(A_TMO_LO, 16'd100);
    bus_rd(A_STAT, d); check("R4 busy after commit", 32'(d[ST_BUSY]), 1);
    wait_idle("R4 busy clears");
    read_cnt(v); check("R4 count loaded", v, 100);
    bus_rd(A_TMO_LO, d); check("R3 timeout low readback", d, 100);
    bus_rd(A_PRE_LO, d); check("R3 pretimeout low readback", d, 20);
    bus_wr(A_MASK, 16'h1);
    bus_rd(A_MASK, d); check("R3 mask readback", d, 1);
  endtask

  task automatic t_busy_drop;
    logic [15:0] d;
    logic [31:0] v;
    bus_wr(A_TMO_LO, 16'd50);
    bus_wr(A_TMO_LO, 16'd77);
    wait_idle("R12 busy clears");
    read_cnt(v); check("R12 count keeps first load", v, 50);
    bus_rd(A_TMO_LO, d); check("R12 register keeps first load", d, 50);
    bus_wr(A_TMO_LO, 16'd100);
    wait_idle("R4 reload busy clears");
  endtask

  task automatic t_count;
    logic [31:0] v, c1, c2;
    bus_wr(A_CTRL, 16'h2);
    wait_cnt(20);
    read_cnt(v); check_rng("R5 count decrements", v, 78, 86);
    bus_wr(A_CTRL, 16'h0);
    wait_cnt(6);
    read_cnt(c1);
    wait_cnt(10);
    read_cnt(c2); check("R5 count holds when disabled", c2, c1);
  endtask

  task automatic t_pretimeout;
    logic [15:0] s;
    logic [31:0] v;
    int n = 0;
    bus_wr(A_CTRL, 16'h3);
    do begin
      bus_rd(A_STAT, s);
      n++;
    end while (!s[ST_INT] && n < 3000);
    check("R6 pretimeout pending", 32'(s[ST_INT]), 1);
    check("R7 no expiry yet", 32'(s[ST_RST]), 0);
    wait_cnt(2);
    read_cnt(v); check_rng("R6 count near threshold", v, 10, 20);
    check("R8 masked irq low", 32'(irq_o), 0);
    bus_wr(A_MASK, 16'h0);
    check("R8 unmasked irq high", 32'(irq_o), 1);
    bus_wr(A_CTRL, 16'h2);
    check("R8 irq needs enable", 32'(irq_o), 0);
    bus_wr(A_CTRL, 16'hB);
    check("R8 irq back on", 32'(irq_o), 1);
  endtask

  task automatic t_expiry;
    logic [15:0] s;
    logic [31:0] v;
    int n = 0;
    do begin
      bus_rd(A_STAT, s);
      n++;
    end while (!s[ST_RST] && n < 3000);
    check("R7 expiry pending", 32'(s[ST_RST]), 1);
    check("R9 reset request high", 32'(rst_req_o), 1);
    wait_cnt(5);
    read_cnt(v); check("R7 count stays zero", v, 0);
    check("R9 reset request held", 32'(rst_req_o), 1);
    bus_wr(A_CTRL, 16'h3);
    check("R9 reset request needs enable", 32'(rst_req_o), 0);
    bus_rd(A_STAT, s); check("R9 pending kept", 32'(s[ST_RST]), 1);
  endtask

  task automatic t_clear;
    logic [15:0] s;
    bus_wr(A_KEY, 16'h0);
    bus_wr(A_CLR, 16'h9);
    bus_rd(A_STAT, s); check("R1 locked clear ignored", s, 16'h9);
    bus_wr(A_KEY, UNLOCK_KEY);
    bus_wr(A_CLR, 16'h1);
    bus_rd(A_STAT, s); check("R10 clear bit0 only", s, 16'h8);
    check("R10 irq low after clear", 32'(irq_o), 0);
    bus_wr(A_CLR, 16'h8);
    bus_rd(A_STAT, s); check("R10 clear bit3", s, 16'h0);
  endtask

  task automatic t_coherent;
    logic [31:0] v;
    int bad = 0, n = 0;
    bus_wr(A_CTRL, 16'h0);
    bus_wr(A_PRE_HI, 16'h0);
    bus_wr(A_PRE_LO, 16'h0);
    bus_wr(A_TMO_HI, 16'h1);
    bus_wr(A_TMO_LO, 16'h3);
    wait_idle("R11 load busy clears");
    read_cnt(v); check("R11 both halves loaded", v, 32'h10003);
    bus_wr(A_CTRL, 16'h2);
    do begin
      read_cnt(v);
      if (v < 32'hFFF0 || v > 32'h10003) bad++;
      n++;
    end while (v > 32'hFFFD && n < 300);
    check("R11 no torn count pairs", bad, 0);
    check_rng("R11 crossed half boundary", v, 32'hFFF0, 32'hFFFD);
    bus_wr(A_CTRL, 16'h0);
  endtask

  initial begin
    #50 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_lock();
    t_load();
    t_busy_drop();
    t_count();
    t_pretimeout();
    t_expiry();
    t_clear();
    t_coherent();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule